// File: doc/BRIEF.md
# Serial Boot-Mode Loader

This block brings a processor's configuration mode bits in from an external serial source at power-up. Once the power-good input is seen high, it runs a slow mode clock derived from the master clock by a factor of 256. It takes one data bit per mode-clock period and writes each bit into a wide mode register that the rest of the chip reads.

After the fixed 256-bit stream has been taken in, the loader raises a done flag and releases the core reset. The mode clock keeps running after that point, but the serial input is no longer sampled. Dropping power-good at any moment returns the loader to idle and clears its progress, so that the next rise of power-good starts a fresh load from the first bit.

Top module: `boot_mode_loader`

## Requirements
- R1: While `rst_n` is low, or while `pwr_good` is low, `mode_sclk`, `load_done`, `core_rst_n` and every bit of `mode_bits` are 0.
- R2: `mode_sclk` goes high in the cycle after the first rising `clk` edge that sees `pwr_good` high. It then stays high for 128 cycles and low for 128 cycles, repeating with a period of 256 cycles.
- R3: `mode_sdi` is sampled once per mode-clock period, at the rising `clk` edge where the high phase has already lasted 65 cycles (divider count 64). Values that `mode_sdi` takes at other times in the period do not reach `mode_bits`.
- R4: `load_done` stays low until the 256th bit has been captured, and rises right after that capture.
- R5: Once `load_done` is high, `mode_sclk` keeps toggling with the R2 timing, while `mode_bits` and `load_done` remain unchanged whatever `mode_sdi` does.
- R6: A low on `pwr_good` at any clock edge clears the bit counter, `load_done` and `mode_bits`, and holds `mode_sclk` low from the next cycle. A later rise of `pwr_good` restarts loading at bit 0.
- R7: The n-th received bit (counting the first as bit 0) is stored at `mode_bits[n]`, so the first received bit appears at `mode_bits[0]` and the last at `mode_bits[255]`.
- R8: `core_rst_n` is low (core held in reset) until `load_done` is high, and is high while `load_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; high starts and sustains loading |
| mode_sdi | input | 1 | Serial mode data from the external source |
| mode_sclk | output | 1 | Mode clock: master clock divided by 256 |
| mode_bits | output | 256 | Captured configuration mode register |
| load_done | output | 1 | High once all mode bits are captured |
| core_rst_n | output | 1 | Active-low core reset, released when loading completes |

## Verification
The bound checker watches, on every cycle, that a capture happens only while the mode clock is high, that the bit index steps by one per capture, and that done rises only right after a capture. It also checks that power-good low forces the clock, counter and flag to idle, that mode bits and done stay frozen once loaded, and that the core reset is never released early. The exact sample instant within the high phase, the placement of each received bit at its own index, the 128/128 clock shape and the restart from bit 0 after an aborted load can only be shown by the bench's scenarios. These scenarios drive wrong data outside a narrow window around the sampling edge and compare the full register against an independently built pattern.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  // Divider count at which the serial input is taken: halfway through
  // the high phase, which occupies the lower half of the divider range.
  function automatic int unsigned sample_count(input int unsigned div_w);
    return (32'd1 << div_w) / 4;
  endfunction

  // Mode clock level for a given divider count: high in the lower half.
  function automatic logic sclk_level(input int unsigned count, input int unsigned div_w);
    return (count < ((32'd1 << div_w) / 2)) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/bml_divider.sv
module bml_divider #(
  parameter int DIV_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic tick
);
  localparam logic [DIV_W-1:0] SAMPLE_AT = DIV_W'(boot_mode_pkg::sample_count(DIV_W));

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign sclk = run & boot_mode_pkg::sclk_level(32'(cnt_q), DIV_W);
  assign tick = run & (cnt_q == SAMPLE_AT);
endmodule

// File: rtl/bml_bit_counter.sv
module bml_bit_counter #(
  parameter int N_BITS = 256,
  parameter int IDX_W  = $clog2(N_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (clear) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (step) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
      if (idx == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/bml_capture.sv
module bml_capture #(
  parameter int N_BITS = 256,
  parameter int IDX_W  = $clog2(N_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              sdi,
  output logic [N_BITS-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clear)  q <= '0;
    else if (we)     q[idx] <= sdi;
  end
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader #(
  parameter int N_BITS = 256,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              mode_sdi,
  output logic              mode_sclk,
  output logic [N_BITS-1:0] mode_bits,
  output logic              load_done,
  output logic              core_rst_n
);
  localparam int IDX_W = $clog2(N_BITS);

  logic             active;
  logic             sample_tick;
  logic             capture_en;
  logic             idle_clear;
  logic [IDX_W-1:0] bit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= pwr_good;
  end

  assign idle_clear = ~pwr_good;
  assign capture_en = sample_tick & ~load_done;

  bml_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (active),
    .sclk (mode_sclk),
    .tick (sample_tick)
  );

  bml_bit_counter #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(idle_clear),
    .step (capture_en),
    .idx  (bit_idx),
    .done (load_done)
  );

  bml_capture #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_cap (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(idle_clear),
    .we   (capture_en),
    .idx  (bit_idx),
    .sdi  (mode_sdi),
    .q    (mode_bits)
  );

  assign core_rst_n = load_done;
endmodule

// File: rtl/bml_checker.sv
module bml_checker #(
  parameter int N_BITS = 256,
  parameter int IDX_W  = $clog2(N_BITS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              mode_sclk,
  input logic [N_BITS-1:0] mode_bits,
  input logic              load_done,
  input logic              core_rst_n,
  input logic              sample_tick,
  input logic              capture_en,
  input logic [IDX_W-1:0]  bit_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_BITS - 1);

  assert_tick_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> mode_sclk);

  assert_done_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> $past(capture_en));

  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && pwr_good) |=> $stable(mode_bits));

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && pwr_good) |=> load_done);

  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!mode_sclk && !load_done && bit_idx == '0));

  assert_index_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && pwr_good && bit_idx != LAST) |=> bit_idx == IDX_W'($past(bit_idx) + 1'b1));

  assert_core_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |-> load_done);
endmodule

bind boot_mode_loader bml_checker #(.N_BITS(N_BITS), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_good   (pwr_good),
  .mode_sclk  (mode_sclk),
  .mode_bits  (mode_bits),
  .load_done  (load_done),
  .core_rst_n (core_rst_n),
  .sample_tick(sample_tick),
  .capture_en (capture_en),
  .bit_idx    (bit_idx)
);

// File: tb/boot_mode_loader_bench.sv
module boot_mode_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 256;
  localparam int WD_CYCLES  = 120000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good = 1'b1;
  logic          mode_sdi = 1'b0;
  logic          mode_sclk;
  logic [NB-1:0] mode_bits;
  logic          load_done;
  logic          core_rst_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [NB-1:0] pat;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_mode_loader u_boot_mode_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .mode_sdi  (mode_sdi),
    .mode_sclk (mode_sclk),
    .mode_bits (mode_bits),
    .load_done (load_done),
    .core_rst_n(core_rst_n)
  );

  task automatic chk(input bit ok, input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bit period of 256 cycles, starting at the negedge just before the
  // period's first rising edge. Correct data only around the sampling edge.
  task automatic drive_bit(input int k);
    mode_sdi = ~pat[k];
    repeat (60) @(negedge clk);
    if (k == 0) chk(mode_sclk == 1'b1, "R2 sclk high early in period", NB'(mode_sclk), NB'(1));
    if (k == NB-1) begin
      chk(load_done == 1'b0, "R4 done low before last capture", NB'(load_done), NB'(0));
      chk(core_rst_n == 1'b0, "R8 core held before done", NB'(core_rst_n), NB'(0));
    end
    mode_sdi = pat[k];
    repeat (8) @(negedge clk);
    mode_sdi = ~pat[k];
    repeat (62) @(negedge clk);
    if (k == 0) chk(mode_sclk == 1'b0, "R2 sclk low after 128 cycles", NB'(mode_sclk), NB'(0));
    repeat (126) @(negedge clk);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk(mode_sclk == 1'b0 && load_done == 1'b0 && core_rst_n == 1'b0,
        "R1 outputs idle in reset", NB'({mode_sclk, load_done, core_rst_n}), NB'(0));
    chk(mode_bits == '0, "R1 mode bits zero in reset", mode_bits, '0);
    pwr_good = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(mode_sclk == 1'b0 && load_done == 1'b0 && core_rst_n == 1'b0,
        "R1 outputs idle without power good", NB'({mode_sclk, load_done, core_rst_n}), NB'(0));
  endtask

  task automatic t_abort_midway();
    pwr_good = 1'b1;
    for (int k = 0; k < 5; k++) drive_bit(k);
    chk(mode_bits == NB'(pat[4:0]), "R7 partial load placement", mode_bits, NB'(pat[4:0]));
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    chk(mode_sclk == 1'b0 && load_done == 1'b0, "R6 abort idles clock and flag",
        NB'({mode_sclk, load_done}), NB'(0));
    chk(mode_bits == '0, "R6 abort clears mode bits", mode_bits, '0);
  endtask

  task automatic t_full_load();
    pwr_good = 1'b1;
    for (int k = 0; k < NB; k++) drive_bit(k);
    chk(mode_bits == pat, "R3 R7 full stream captured in order", mode_bits, pat);
    chk(mode_bits[0] == pat[0] && mode_bits[NB-1] == pat[NB-1], "R6 restart begins at bit 0",
        NB'({mode_bits[NB-1], mode_bits[0]}), NB'({pat[NB-1], pat[0]}));
    chk(load_done == 1'b1, "R4 done after last bit", NB'(load_done), NB'(1));
    chk(core_rst_n == 1'b1, "R8 core released", NB'(core_rst_n), NB'(1));
  endtask

  task automatic t_after_done();
    logic [NB-1:0] held;
    int rises;
    logic prev;
    held = mode_bits;
    rises = 0;
    prev = mode_sclk;
    for (int c = 0; c < 512; c++) begin
      mode_sdi = ~mode_sdi;
      @(negedge clk);
      if (mode_sclk && !prev) rises++;
      prev = mode_sclk;
    end
    chk(rises == 2, "R5 mode clock keeps toggling", NB'(rises), NB'(2));
    chk(mode_bits == held, "R5 later data ignored", mode_bits, held);
    chk(load_done == 1'b1, "R5 done held", NB'(load_done), NB'(1));
  endtask

  task automatic t_drop_after_done();
    pwr_good = 1'b0;
    repeat (2) @(negedge clk);
    chk(load_done == 1'b0 && core_rst_n == 1'b0, "R6 R8 power drop re-arms reset",
        NB'({load_done, core_rst_n}), NB'(0));
    chk(mode_bits == '0 && mode_sclk == 1'b0, "R6 power drop clears state",
        mode_bits, '0);
  endtask

  initial begin
    for (int i = 0; i < NB; i++)
      pat[i] = (((i * 37 + 11) >> 2) & 1) != 0 ? (i % 3 != 0) : (i % 3 == 0);
    t_reset_state();
    t_abort_midway();
    t_full_load();
    t_after_done();
    t_drop_after_done();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule